// File: doc/BRIEF.md
# Chained Serial Register-Access Port

This block is a serial slave for register access that is meant to sit in a chain of identical slaves. Every slave shares the clock and the active-low select line. Each slave's serial output feeds the serial input of the next slave, and the last output returns to the host. While select is low, a fixed 24-bit frame moves through the slave's shift register. Whatever frame the slave held before comes out on the serial output as the new one goes in. A slave therefore needs no address of its own: its position in the chain decides which frame it ends up holding when select rises.

On the rising edge of select, the slave decodes the frame it holds and acts on it. A frame of the wrong length is dropped. A well-formed frame carries a 12-bit address that falls into one of nine 256-byte regions. Eight of these regions are split into four ports with two logical devices each, and the ninth is the block's own register space. A valid frame produces a one-cycle read or write strobe on a parallel register bus in the system clock domain. For a read, the byte that comes back is written into the data field of the held frame, so the host gets it during the next frame.

The serial pins are brought into the system clock by synchronizers, and all shifting is done in that domain. The system clock must therefore run several times faster than the serial clock. Only the output enable does not pass through the synchronizers: it follows select combinationally.

Top module: `spi_chain_regport`

## Requirements
- R1: A frame is 24 bits and is sent MSB first. Bit 23 is the access type (1 = read, 0 = write), bits 22..20 are reserved, bits 19..8 are the address and bits 7..0 are the data. Input is sampled on rising serial clock and output advances on falling serial clock (mode 0). The frame is acted on only after select rises, never while it is low.
- R2: While select is high, the serial output is high impedance and clock or data activity on the input changes nothing: the next frame shifted out is still the frame held before.
- R3: The serial output is driven as soon as select goes low, with no clock edge needed, and its first bit is the MSB of the held frame.
- R4: During each transfer, the frame held before it (reserved bits included) is shifted out bit for bit, MSB first.
- R5: If select rises after any number of bits other than 24, no register-bus access is issued.
- R6: For a write to address region r = addr[11:8] with r < 8, exactly one write strobe is issued. It carries port = r / 2, device = r % 2, local flag 0, offset = addr[7:0] and the frame's data byte.
- R7: For region 8 (addresses 0x800..0x8FF), the strobe carries local flag 1 with port 0 and device 0.
- R8: For regions 9..15, no access is issued, yet the frame is still held and shifted out in the next transfer.
- R9: A read issues one read strobe with the same decoded fields. The bus read data is sampled one clock after the strobe, and the sampled value replaces bits 7..0 of the held frame, so it appears in the next transfer.
- R10: Read and write strobes never occur together, and each lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, shared by the chain |
| spi_cs_n | input | 1 | Active-low select, shared by the chain |
| spi_mosi | input | 1 | Serial input from the host or the previous slave |
| spi_miso | output | 1 | Serial output to the next slave or the host; high impedance while deselected |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_port | output | 2 | Decoded port index |
| bus_dev | output | 1 | Decoded logical device index within the port |
| bus_local | output | 1 | Access targets the block's own registers |
| bus_offset | output | 8 | Byte offset within the 256-byte region |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid one clock after bus_rd |

## Verification
A shift register that slips by one bit, or a miscounted frame, shows up in the very next transfer: the frame shifted out no longer matches the one shifted in, and that can be checked bit by bit at the serial output. A wrong region decode shows up at the strobe itself, within a few system clocks of select rising, as a wrong port, device or local flag, or as a strobe that is missing or spurious. A read-data load in the wrong cycle, or into the wrong field, only becomes visible one transfer later, in the data byte that returns on the serial output.

// File: rtl/spi_chain_pkg.sv
// Shared frame geometry for the chained serial register-access port.
// Assumes a fixed frame: access type, reserved bits, address, data (MSB first).
package spi_chain_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 12;
    localparam int RSV_W    = 3;
    localparam int OFFSET_W = 8;
    localparam int FRAME_W  = 1 + RSV_W + ADDR_W + DATA_W;
    localparam int REGION_W = ADDR_W - OFFSET_W;
    localparam int ADDR_LSB = DATA_W;
    localparam int RW_BIT   = FRAME_W - 1;
endpackage

// File: rtl/spi_chain_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; reset loads RESET_VAL into every stage.
module spi_chain_sync #(
    parameter int WIDTH               = 3,
    parameter int STAGES              = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Moves the sample one stage closer to the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RESET_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_chain_shifter.sv
// Frame shift register for one slave in the chain, clocked by the system clock.
// Uses synchronized serial clock/select/data, finds their edges, latches input
// on rising serial clock and shifts on falling serial clock. When select rises,
// it flags execution if exactly FRAME_W bits were shifted. A read-data load
// overwrites the data field of the held frame.
// Assumes the system clock is at least ~6x the serial clock.
module spi_chain_shifter
    import spi_chain_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               cs_n_s,
    input  logic               mosi_s,
    input  logic               rd_load,
    input  logic [DATA_W-1:0]  rd_byte,
    output logic [FRAME_W-1:0] frame_q,
    output logic               exec_q
);
    localparam int CNT_SAT = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);

    logic             sck_prev;
    logic             cs_prev;
    logic             in_bit;
    logic [CNT_W-1:0] bit_cnt;

    logic sck_rise, sck_fall, sel_fall, sel_rise;

    // Edge detection on the synchronized serial clock and select.
    always_comb begin
        sck_rise = sck_s & ~sck_prev;
        sck_fall = ~sck_s & sck_prev;
        sel_fall = ~cs_n_s & cs_prev;
        sel_rise = cs_n_s & ~cs_prev;
    end

    // Shift, count, execution flag and read-data insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
            in_bit   <= 1'b0;
            bit_cnt  <= '0;
            frame_q  <= '0;
            exec_q   <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_n_s;
            exec_q   <= 1'b0;
            if (sel_fall) begin
                bit_cnt <= '0;
            end else if (sel_rise) begin
                exec_q <= (bit_cnt == CNT_W'(FRAME_W));
            end else if (!cs_n_s) begin
                if (sck_rise) begin
                    in_bit <= mosi_s;
                end
                if (sck_fall) begin
                    frame_q <= {frame_q[FRAME_W-2:0], in_bit};
                    if (bit_cnt != CNT_W'(CNT_SAT)) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
            if (rd_load) begin
                frame_q[DATA_W-1:0] <= rd_byte;
            end
        end
    end

    AST_HOLD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && cs_prev && !rd_load) |=> $stable(frame_q[FRAME_W-1:DATA_W])); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_SAT)); // R5
    AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> !exec_q); // R1
endmodule

// File: rtl/spi_chain_decode.sv
// Address decoder and register-bus strobe generator.
// Splits the 12-bit address into a region and a byte offset. Regions below
// NUM_PORTS*DEVS_PER_PORT select (port, device), the next region selects local
// registers, and higher regions are ignored. It also produces the read-data
// load one cycle after a read strobe.
// Assumes exec is a one-cycle pulse with a stable frame behind it.
module spi_chain_decode
    import spi_chain_pkg::*;
#(
    parameter int NUM_PORTS     = 4,
    parameter int DEVS_PER_PORT = 2,
    parameter int PORT_W        = 2,
    parameter int DEV_W         = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exec,
    input  logic                acc_read,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_data,
    output logic                bus_wr,
    output logic                bus_rd,
    output logic [PORT_W-1:0]   bus_port,
    output logic [DEV_W-1:0]    bus_dev,
    output logic                bus_local,
    output logic [OFFSET_W-1:0] bus_offset,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                rd_load
);
    localparam int LOCAL_REGION = NUM_PORTS * DEVS_PER_PORT;

    logic [REGION_W-1:0] region;
    logic                mapped;
    logic                is_local;

    // Region split and mapping test.
    always_comb begin
        region   = acc_addr[ADDR_W-1:OFFSET_W];
        mapped   = int'(region) <= LOCAL_REGION;
        is_local = int'(region) == LOCAL_REGION;
    end

    // Registered strobes and fields, plus the delayed read-data load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr     <= 1'b0;
            bus_rd     <= 1'b0;
            bus_port   <= '0;
            bus_dev    <= '0;
            bus_local  <= 1'b0;
            bus_offset <= '0;
            bus_wdata  <= '0;
            rd_load    <= 1'b0;
        end else begin
            bus_wr  <= 1'b0;
            bus_rd  <= 1'b0;
            rd_load <= bus_rd;
            if (exec && mapped) begin
                bus_wr     <= ~acc_read;
                bus_rd     <= acc_read;
                bus_offset <= acc_addr[OFFSET_W-1:0];
                bus_wdata  <= acc_data;
                bus_local  <= is_local;
                if (is_local) begin
                    bus_port <= '0;
                    bus_dev  <= '0;
                end else begin
                    bus_port <= PORT_W'(int'(region) / DEVS_PER_PORT);
                    bus_dev  <= DEV_W'(int'(region) % DEVS_PER_PORT);
                end
            end
        end
    end

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R10
    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> !(bus_wr || bus_rd)); // R10
    AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> $past(exec)); // R1
    AST_LOCAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_local) |-> (bus_port == '0 && bus_dev == '0)); // R7
    AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> $past(bus_rd)); // R9
endmodule

// File: rtl/spi_chain_regport.sv
// Top of the chained serial register-access slave.
// Synchronizes the serial pins, shifts frames, decodes and executes them on
// select rising, and returns read data into the held frame. The output enable
// follows select combinationally, so the held MSB appears when select falls.
// Assumes the system clock runs several times faster than the serial clock.
module spi_chain_regport
    import spi_chain_pkg::*;
#(
    parameter int NUM_PORTS     = 4,
    parameter int DEVS_PER_PORT = 2,
    parameter int SYNC_STAGES   = 2,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int DEV_W  = (DEVS_PER_PORT > 1) ? $clog2(DEVS_PER_PORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    output logic                bus_wr,
    output logic                bus_rd,
    output logic [PORT_W-1:0]   bus_port,
    output logic [DEV_W-1:0]    bus_dev,
    output logic                bus_local,
    output logic [OFFSET_W-1:0] bus_offset,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata
);
    logic [2:0]         pins_s;
    logic [FRAME_W-1:0] frame_q;
    logic               exec_q;
    logic               rd_load;

    spi_chain_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_sck, spi_cs_n, spi_mosi}),
        .q_sync  (pins_s)
    );

    spi_chain_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[2]),
        .cs_n_s  (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .rd_load (rd_load),
        .rd_byte (bus_rdata),
        .frame_q (frame_q),
        .exec_q  (exec_q)
    );

    spi_chain_decode #(
        .NUM_PORTS     (NUM_PORTS),
        .DEVS_PER_PORT (DEVS_PER_PORT),
        .PORT_W        (PORT_W),
        .DEV_W         (DEV_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec       (exec_q),
        .acc_read   (frame_q[RW_BIT]),
        .acc_addr   (frame_q[ADDR_LSB +: ADDR_W]),
        .acc_data   (frame_q[DATA_W-1:0]),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_port   (bus_port),
        .bus_dev    (bus_dev),
        .bus_local  (bus_local),
        .bus_offset (bus_offset),
        .bus_wdata  (bus_wdata),
        .rd_load    (rd_load)
    );

    // Output driver: enabled directly by select, high impedance when deselected.
    assign spi_miso = spi_cs_n ? 1'bz : frame_q[FRAME_W-1];
endmodule

// File: tb/tb_spi_chain_regport.sv
module tb_spi_chain_regport;
    localparam int HALF = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       bus_wr, bus_rd, bus_dev, bus_local;
    logic [1:0] bus_port;
    logic [7:0] bus_offset, bus_wdata;
    logic [7:0] bus_rdata = 8'h00;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [1:0] l_port;
    logic       l_dev, l_local;
    logic [7:0] l_off, l_wdata;
    logic [7:0] mem [0:8][0:255];

    logic [23:0] exp_held = 24'h0;
    logic        exp_valid = 1'b1;
    logic        prev_read = 1'b0;

    always #5 clk = ~clk;

    spi_chain_regport dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_port(bus_port), .bus_dev(bus_dev), .bus_local(bus_local),
        .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Register-bus model and strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (bus_wr) begin
            wr_cnt++;
            l_port = bus_port; l_dev = bus_dev; l_local = bus_local;
            l_off = bus_offset; l_wdata = bus_wdata;
            mem[bus_local ? 8 : int'(bus_port) * 2 + int'(bus_dev)][bus_offset] = bus_wdata;
        end
        if (bus_rd) begin
            rd_cnt++;
            l_port = bus_port; l_dev = bus_dev; l_local = bus_local; l_off = bus_offset;
            bus_rdata = mem[bus_local ? 8 : int'(bus_port) * 2 + int'(bus_dev)][bus_offset];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pattern(input int region, input int off);
        return 8'(((region * 37) + (off * 3)) ^ 8'hA5);
    endfunction

    function automatic logic [23:0] mkframe(input bit rd, input logic [11:0] addr, input logic [7:0] d);
        return {rd, 3'b101, addr, d};
    endfunction

    // One host transfer of nbits; checks R3 and the returned frame (R4/R9).
    task automatic xfer(input logic [23:0] tx, input int nbits);
        logic [23:0] rx = '0;
        spi_cs_n = 1'b0;
        #2;
        if (exp_valid) chk(spi_miso === exp_held[23], "R3", {31'b0, spi_miso}, {31'b0, exp_held[23]});
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 24) ? tx[23 - i] : 1'b0;
            #(HALF);
            rx = {rx[22:0], spi_miso};
            spi_sck = 1'b1;
            #(HALF);
            spi_sck = 1'b0;
        end
        #(HALF);
        spi_cs_n = 1'b1;
        #(HALF * 3);
        if (exp_valid && nbits == 24)
            chk(rx == exp_held, prev_read ? "R9" : "R4", {8'b0, rx}, {8'b0, exp_held});
        exp_valid = (nbits == 24);
        exp_held  = tx;
        prev_read = 1'b0;
    endtask

    task automatic write_chk(input logic [11:0] addr, input logic [7:0] d);
        int w0 = wr_cnt, r0 = rd_cnt;
        int region = int'(addr[11:8]);
        xfer(mkframe(1'b0, addr, d), 24);
        if (region <= 8) begin
            chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R6", 32'(wr_cnt - w0), 32'd1);
            chk(l_local == (region == 8), "R7", {31'b0, l_local}, {31'b0, region == 8});
            chk(l_port == ((region == 8) ? 2'd0 : 2'(region / 2)), "R6", {30'b0, l_port}, 32'(region / 2));
            chk(l_dev == ((region == 8) ? 1'b0 : 1'(region % 2)), "R6", {31'b0, l_dev}, 32'(region % 2));
            chk(l_off == addr[7:0] && l_wdata == d, "R6", {16'b0, l_off, l_wdata}, {16'b0, addr[7:0], d});
        end else begin
            chk(wr_cnt == w0 && rd_cnt == r0, "R8", 32'(wr_cnt - w0), 32'd0);
        end
    endtask

    task automatic read_chk(input logic [11:0] addr);
        int w0 = wr_cnt, r0 = rd_cnt;
        int region = int'(addr[11:8]);
        xfer(mkframe(1'b1, addr, 8'h3C), 24);
        chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R10", 32'(rd_cnt - r0), 32'd1);
        chk(l_local == (region == 8) && l_off == addr[7:0], "R9", {23'b0, l_local, l_off}, {23'b0, region == 8, addr[7:0]});
        chk(l_port == ((region == 8) ? 2'd0 : 2'(region / 2)), "R9", {30'b0, l_port}, 32'(region / 2));
        exp_held[7:0] = pattern(region, int'(addr[7:0]));
        prev_read = 1'b1;
    endtask

    initial begin
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int offs [3] = '{0, 8'h5A, 8'hFF};
        int w0, r0;
        repeat (5) @(posedge clk);
        #3 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #3;
        chk(spi_miso === 1'bz, "R2", {31'b0, spi_miso}, 32'b0);
        chk(!bus_wr && !bus_rd && wr_cnt == 0, "R10", {31'b0, bus_wr}, 32'b0);

        // Write sweep over all mapped regions.
        for (int r = 0; r < 9; r++)
            for (int k = 0; k < 3; k++)
                write_chk({4'(r), 8'(offs[k])}, pattern(r, offs[k]));
        // Read sweep: data returns in the following frame.
        for (int r = 0; r < 9; r++)
            for (int k = 0; k < 3; k++)
                read_chk({4'(r), 8'(offs[k])});

        // Unmapped regions: no access, frame still passes.
        write_chk(12'h9AB, 8'h11);
        write_chk(12'hF12, 8'h22);
        w0 = wr_cnt; r0 = rd_cnt;
        xfer(mkframe(1'b1, 12'hC00, 8'h33), 24);
        chk(rd_cnt == r0 && wr_cnt == w0, "R8", 32'(rd_cnt - r0), 32'd0);

        // Wrong lengths are discarded.
        w0 = wr_cnt; r0 = rd_cnt;
        xfer(mkframe(1'b0, 12'h123, 8'h44), 20);
        chk(wr_cnt == w0 && rd_cnt == r0, "R5", 32'(wr_cnt - w0), 32'd0);
        xfer(mkframe(1'b0, 12'h234, 8'h55), 26);
        chk(wr_cnt == w0 && rd_cnt == r0, "R5", 32'(wr_cnt - w0), 32'd0);
        write_chk(12'h345, 8'h66);

        // Activity while deselected is ignored and the output floats.
        for (int i = 0; i < 6; i++) begin
            spi_mosi = i[0];
            spi_sck = 1'b1; #(HALF);
            chk(spi_miso === 1'bz, "R2", {31'b0, spi_miso}, 32'b0);
            spi_sck = 1'b0; #(HALF);
        end
        w0 = wr_cnt;
        chk(wr_cnt == w0, "R2", 32'(wr_cnt - w0), 32'd0);
        write_chk(12'h0FE, 8'h77);
        write_chk(12'h8F0, 8'h88);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule